// File: doc/BRIEF.md
# Self-Timed Half-Adder Iterative Adder

This block adds two unsigned operands with one row of half adders whose outputs are registered and fed back as the next pair of inputs. The first pass forms the bitwise XOR as the partial sum and the bitwise AND, shifted up one place, as the pending carries. Each later clock applies the same half-adder row to the partial sum and the pending carries. The block stops when no carry is left. A carry that leaves the top bit is caught in a separate register and becomes the most significant result bit.

The number of cycles depends on the data. It follows the longest carry chain in the operands and does not depend on the width. Operands enter through a valid/ready port. The result leaves through a second valid/ready port and stays on the output until it is taken. Only one addition is in flight at a time. `in_ready` is low from the accepting edge until the result has been transferred. A consumer may hold `out_ready` low for any number of cycles, and the result and its valid bit stay frozen while it does.

Top module: `ha_iter_adder`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Operands are taken only at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the result is transferred, and `in_valid` pulses with other operands during that time do not change the result.
- R3: When `out_valid` is 1, `out_sum` equals `in_a + in_b` computed at WIDTH+1 bits, for the operands that were taken.
- R4: Define a carry chain as a bit g with a[g]=b[g]=1, with length 1 plus the number of consecutive bits above g where a XOR b is 1. L is the longest such chain, or 0 if there is none. Counting the accepting edge as edge 1, `out_valid` is first seen 1 after edge L+1, and the number of pending carries never grows from one iteration to the next.
- R5: Operands with no bit where both are 1 give a result right after the accepting edge (L=0, one edge).
- R6: All-ones plus one needs WIDTH+1 edges, and no addition takes more than WIDTH iterations after the first pass.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sum` holds its value. After an edge with both at 1, `out_valid` is 0 and `in_ready` is 1.
- R8: The carry out of bit WIDTH-1 appears as `out_sum[WIDTH]`, including a carry that only leaves the top bit after several iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on `in_a`/`in_b` are offered |
| in_ready | output | 1 | Block is idle and will take operands |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | `out_sum` holds a finished result |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | WIDTH+1 | Sum with the carry out in the top bit |

## Verification
The hardest case to reach from the ports is a busy adder that sees new operands offered while its carries are still moving. The offer must come exactly in the cycles where the adder is busy, and it must be proven to have had no effect. The stimulus uses operands with long carry chains, such as all ones plus one and a low byte of ones plus one. It asserts `in_valid` with unrelated operands only in cycles where `in_ready` reads 0, and then compares the eventual sum and latency with values predicted from the first pair. Back-pressure is reached the same way: the consumer side withholds `out_ready` for several cycles after a result appears and samples the output in each of those cycles.

// File: rtl/ha_iter_pkg.sv
package ha_iter_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ha_state_e;
endpackage

// File: rtl/ha_row.sv
module ha_row #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] s,
  output logic [WIDTH:1]   c
);
  // one half adder per bit: sum stays in place, carry moves up one bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign s[i]   = x[i] ^ y[i];
    assign c[i+1] = x[i] & y[i];
  end
endmodule

// File: rtl/ha_zero.sv
module ha_zero #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] v,
  output logic             zero
);
  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PADW = NGRP * GROUP;

  logic [PADW-1:0] padded;
  logic [NGRP-1:0] grp_any;

  assign padded = {{(PADW-WIDTH){1'b0}}, v};

  // two-level NOR: OR inside each group, then NOR of the group flags
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign zero = ~|grp_any;
endmodule

// File: rtl/ha_ctrl.sv
module ha_ctrl
  import ha_iter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic settled,
  output logic in_ready,
  output logic out_valid,
  output logic busy,
  output logic load,
  output logic step
);
  ha_state_e state_q, state_d;

  assign busy      = (state_q == ST_BUSY);
  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = busy && settled;
  assign load      = in_valid && in_ready;
  assign step      = busy && !settled;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load) state_d = ST_BUSY;
      ST_BUSY: if (out_valid && out_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);

  a_r2_locked_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !in_ready);
endmodule

// File: rtl/ha_iter_adder.sv
module ha_iter_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH:0]   out_sum
);
  localparam int CNTW = $clog2(WIDTH + 2);

  logic [WIDTH-1:0] sum_q;
  logic [WIDTH:1]   cry_q;
  logic             cout_q;

  logic [WIDTH-1:0] row_x, row_y, row_s;
  logic [WIDTH:1]   row_c;
  logic             busy, load, step, settled;

  // carry into bit 0 is always zero
  assign row_x = busy ? sum_q : in_a;
  assign row_y = busy ? {cry_q[WIDTH-1:1], 1'b0} : in_b;

  ha_row #(.WIDTH(WIDTH)) u_row (
    .x(row_x), .y(row_y), .s(row_s), .c(row_c)
  );

  ha_zero #(.WIDTH(WIDTH)) u_zero (
    .v(cry_q), .zero(settled)
  );

  ha_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .settled  (settled),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .busy     (busy),
    .load     (load),
    .step     (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cry_q  <= '0;
      cout_q <= 1'b0;
    end else if (load) begin
      sum_q  <= row_s;
      cry_q  <= row_c;
      cout_q <= 1'b0;
    end else if (step) begin
      sum_q  <= row_s;
      cry_q  <= row_c;
      cout_q <= cout_q | cry_q[WIDTH];
    end
  end

  assign out_sum = {cout_q, sum_q};

  // iteration counter, used only by the bound check below
  logic [CNTW-1:0] iter_q;
  always_ff @(posedge clk) begin
    if (!rst_n || load) iter_q <= '0;
    else if (step)      iter_q <= iter_q + 1'b1;
  end

  a_r6_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> iter_q <= CNTW'(WIDTH));

  a_r4_carries_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $countones(cry_q) <= $past($countones(cry_q)));

  a_r7_sum_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_sum));

  a_r3_top_carry_once: assert property (@(posedge clk) disable iff (!rst_n)
    step && cout_q |-> !cry_q[WIDTH]);
endmodule

// File: tb/sim_ha_iter_adder.sv
module sim_ha_iter_adder;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  typedef struct {
    logic [W:0] sum;
    int         lat;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W:0] out_sum;

  int checks = 0, errors = 0;
  int cyc = 0;
  int hold_cycles = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ha_iter_adder #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int chain_len(input logic [W-1:0] a, input logic [W-1:0] b);
    int best = 0;
    for (int g = 0; g < W; g++) begin
      if (a[g] && b[g]) begin
        int len = 1;
        int j = g + 1;
        while (j < W && (a[j] ^ b[j])) begin
          len++;
          j++;
        end
        if (len > best) best = len;
      end
    end
    return best;
  endfunction

  int accept_cyc = 0;

  // driver: offers one pair, records the expectation, optionally
  // pokes junk operands while busy (R2)
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input int hold, input bit junk, input string tag);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    e.sum = {1'b0, a} + {1'b0, b};
    e.lat = chain_len(a, b) + 1;
    e.tag = tag;
    sb.push_back(e);
    hold_cycles = hold;
    in_a = a; in_b = b; in_valid = 1'b1;
    accept_cyc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    if (junk) begin
      for (int k = 0; k < 3; k++) begin
        if (!in_ready) begin
          check(in_ready == 1'b0, "R2", "in_ready while busy", in_ready, 0);
          in_a = ~a; in_b = 16'h1234; in_valid = 1'b1;
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor: measures latency, applies back-pressure, compares results
  initial begin
    bit first;
    int lat;
    logic [W:0] held;
    first = 1'b1;
    forever begin
      @(negedge clk);
      if (out_valid && sb.size() != 0) begin
        if (first) begin
          first = 1'b0;
          lat = cyc - accept_cyc;
          check(lat == sb[0].lat, "R4", {"latency ", sb[0].tag}, lat, sb[0].lat);
          check(out_sum == sb[0].sum, "R3", {"sum ", sb[0].tag}, out_sum, sb[0].sum);
          if (hold_cycles > 0) begin
            out_ready = 1'b0;
            held = out_sum;
            for (int h = 0; h < hold_cycles; h++) begin
              @(negedge clk);
              check(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
              check(out_sum == held, "R7", "sum held", out_sum, held);
            end
            out_ready = 1'b1;
          end
        end
        if (out_ready) begin
          @(negedge clk);
          check(in_ready == 1'b1 && out_valid == 1'b0, "R7", "release",
                {in_ready, out_valid}, 2'b10);
          void'(sb.pop_front());
          first = 1'b1;
        end
      end
    end
  end

  initial begin
    while (cyc < WATCHDOG && !finished) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
          {in_ready, out_valid}, 2'b10);

    drive(16'h0000, 16'h0000, 0, 0, "R5 zero");
    drive(16'h5555, 16'hAAAA, 0, 0, "R5 disjoint");
    drive(16'h0001, 16'h0001, 0, 0, "R4 short");
    drive(16'hFFFF, 16'h0001, 0, 0, "R6 R8 worst");
    drive(16'hFFFF, 16'hFFFF, 0, 0, "R8 all gen");
    drive(16'h8000, 16'h8000, 0, 0, "R8 top");
    drive(16'h00FF, 16'h0001, 0, 1, "R2 junk busy");
    drive(16'h7FFF, 16'h0001, 4, 1, "R2 R7 hold");
    drive(16'h0F0F, 16'h0101, 3, 0, "R7 hold2");
    lfsr = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a;
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(a, lfsr, n % 3, 0, "R3 R4 mix");
    end
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R3", "scoreboard empty", sb.size(), 0);
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule